// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit forms the memory address for each access a core makes. A request gives an offset and a reference kind. The kind picks one of three segment register values presented at the inputs: instruction fetch uses the code segment, stack references use the stack segment, and all other references use the data segment. The unit returns an address one clock after it accepts the request.

The unit leaves reset in real-address mode. In that mode it multiplies the segment value by sixteen and adds the low 16 bits of the offset, which gives a 20-bit address. A one-cycle pulse on a control input moves the unit, through a single switching state, into protected mode. It stays there until reset.

In protected mode the segment value is a selector. The selector picks a descriptor from one of two small on-chip tables, one shared and one per-task, which are loaded through a write port. The descriptor supplies a 32-bit base, a 20-bit limit, a granularity flag and an operand-size flag. The full 32-bit offset is added to the base. The offset is also checked against the limit, scaled by the granularity flag. An access that breaks a rule produces a one-cycle fault pulse and no address.

The control state machine has three states:
- `S_REAL`: requests are accepted and use real-mode addressing. A pulse on `prot_en` moves the machine to `S_SWITCH`.
- `S_SWITCH`: lasts exactly one cycle, and no request is accepted. The machine then always moves to `S_PROT`.
- `S_PROT`: requests are accepted and use descriptor addressing. The state is left only by reset.

Top module: `sag_unit`

## Requirements
- R1: After reset the unit is in `S_REAL`, `req_ready` is 1, and `res_valid`, `res_fault`, `res_addr` and `res_dsize` are all 0.
- R2: In real mode the result address is `(segment * 16 + req_off[15:0]) mod 2^20`, zero-extended to 32 bits. Offset bits 31:16 are ignored, `res_dsize` is 0, and real mode never faults.
- R3: `req_kind` selects the segment value: 1 selects `seg_cs`, 2 selects `seg_ss`, and 0 or 3 selects `seg_ds`. This holds in both modes.
- R4: A `prot_en` pulse accepted in `S_REAL` does not affect a request in the same cycle, which still uses real mode. `req_ready` is 0 for exactly the next cycle, and any request offered then is dropped. Protected mode follows and stays in place, and further `prot_en` pulses have no effect.
- R5: In protected mode the selector is decoded as follows. Bits 15:3 are the descriptor index. Bit 2 picks the table, 0 for shared and 1 for per-task. Bits 1:0 have no effect on the result.
- R6: A descriptor is 64 bits wide. Its limit is bits {51:48, 15:0}, its base is bits {63:56, 39:16}, its granularity flag is bit 55 and its size flag is bit 54. The result address is `(base + req_off) mod 2^32`.
- R7: The effective limit is the limit itself when granularity is 0. When granularity is 1, it is `limit * 4096 + 4095`. An offset equal to the effective limit is valid. An offset above it faults.
- R8: Index 0 of the shared table faults, whatever the entry holds. Index 0 of the per-task table is an ordinary descriptor.
- R9: An index at or above `TBL_DEPTH` faults. The top implemented index is valid.
- R10: Each accepted request produces exactly one one-cycle pulse on `res_valid` or on `res_fault`, never both, on the clock edge after acceptance. In every other cycle both are 0. `res_addr` and `res_dsize` are 0 whenever `res_valid` is 0.
- R11: On a valid protected-mode result, `res_dsize` equals the descriptor's size flag.
- R12: A table write and a lookup of the same entry in the same cycle give the lookup the old entry. The new entry is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Pulse that requests the switch to protected mode |
| seg_cs | input | 16 | Code segment value or selector |
| seg_ss | input | 16 | Stack segment value or selector |
| seg_ds | input | 16 | Data segment value or selector |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | Reference kind: 0 data, 1 fetch, 2 stack, 3 data |
| req_off | input | 32 | Offset |
| dt_wr_en | input | 1 | Descriptor table write strobe |
| dt_wr_local | input | 1 | Write target: 0 shared table, 1 per-task table |
| dt_wr_idx | input | IDX_W (4) | Entry written |
| dt_wr_data | input | 64 | Descriptor written |
| res_valid | output | 1 | Address result pulse |
| res_fault | output | 1 | Fault pulse |
| res_addr | output | 32 | Resulting address |
| res_dsize | output | 1 | Operand-size flag of the result |

## Verification
A descriptor table write and a lookup can fall in the same cycle. The bench provokes this by rewriting a shared-table entry with a new base and size flag while it offers a request through that same selector. It then repeats the request in the following cycle. The reference model applies its table update only after computing the expected result for that cycle, so the first result must carry the old base and the second the new one. The mode switch pulse is also offered together with a request, which must still be handled in real mode.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        S_REAL   = 2'd0,
        S_SWITCH = 2'd1,
        S_PROT   = 2'd2
    } sag_state_e;

    localparam logic [1:0] KIND_DATA  = 2'd0;
    localparam logic [1:0] KIND_FETCH = 2'd1;
    localparam logic [1:0] KIND_STACK = 2'd2;

    localparam int DESC_W  = 64;
    localparam int SEG_W   = 16;
    localparam int LIN_W   = 32;
    localparam int REAL_W  = 20;
    localparam int LIMIT_W = 20;

    typedef struct packed {
        logic [LIN_W-1:0]   base;
        logic [LIMIT_W-1:0] limit;
        logic               gran;
        logic               dsize;
    } seg_desc_t;

    function automatic seg_desc_t unpack_desc(input logic [DESC_W-1:0] raw);
        seg_desc_t d;
        d.limit = {raw[51:48], raw[15:0]};
        d.base  = {raw[63:56], raw[39:16]};
        d.gran  = raw[55];
        d.dsize = raw[54];
        return d;
    endfunction

endpackage

// File: rtl/sag_mode_fsm.sv
module sag_mode_fsm
    import sag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prot_en,
    output logic mode_prot,
    output logic accept_ok
);

    sag_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_REAL;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_REAL:   if (prot_en) st_d = S_SWITCH;
            S_SWITCH: st_d = S_PROT;
            S_PROT:   st_d = S_PROT;
            default:  st_d = S_REAL;
        endcase
    end

    always_comb begin
        mode_prot = 1'b0;
        accept_ok = 1'b1;
        unique case (st_q)
            S_REAL:   begin mode_prot = 1'b0; accept_ok = 1'b1; end
            S_SWITCH: begin mode_prot = 1'b0; accept_ok = 1'b0; end
            S_PROT:   begin mode_prot = 1'b1; accept_ok = 1'b1; end
            default:  begin mode_prot = 1'b0; accept_ok = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sag_desc_table.sv
module sag_desc_table
    import sag_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DESC_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DESC_W-1:0] rd_data
);

    logic [DESC_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/sag_limit_chk.sv
module sag_limit_chk
    import sag_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    input  logic [LIN_W-1:0]  off,
    output logic [LIN_W-1:0]  lin,
    output logic              over,
    output logic              dsize
);

    seg_desc_t        d;
    logic [LIN_W-1:0] eff_limit;

    always_comb begin
        d         = unpack_desc(raw);
        eff_limit = d.gran ? {d.limit, 12'hFFF} : {12'h000, d.limit};
        over      = off > eff_limit;
        lin       = d.base + off;
        dsize     = d.dsize;
    end

endmodule

// File: rtl/sag_unit.sv
module sag_unit
    import sag_pkg::*;
#(
    parameter  int TBL_DEPTH = 16,
    localparam int IDX_W     = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic [SEG_W-1:0]  seg_cs,
    input  logic [SEG_W-1:0]  seg_ss,
    input  logic [SEG_W-1:0]  seg_ds,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [LIN_W-1:0]  req_off,
    input  logic              dt_wr_en,
    input  logic              dt_wr_local,
    input  logic [IDX_W-1:0]  dt_wr_idx,
    input  logic [DESC_W-1:0] dt_wr_data,
    output logic              res_valid,
    output logic              res_fault,
    output logic [LIN_W-1:0]  res_addr,
    output logic              res_dsize
);

    localparam logic [12:0] IDX_LIMIT = 13'(TBL_DEPTH);

    logic              mode_prot;
    logic              accept_ok;
    logic [SEG_W-1:0]  seg;
    logic [12:0]       sel_idx;
    logic              sel_local;
    logic [REAL_W-1:0] real_addr;
    logic [DESC_W-1:0] tbl_rd [2];
    logic [LIN_W-1:0]  prot_addr;
    logic              over;
    logic              desc_dsize;
    logic              prot_fault;
    logic              accept;

    sag_mode_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_en   (prot_en),
        .mode_prot (mode_prot),
        .accept_ok (accept_ok)
    );

    assign req_ready = accept_ok;
    assign accept    = req_valid && accept_ok;

    always_comb begin
        unique case (req_kind)
            KIND_FETCH: seg = seg_cs;
            KIND_STACK: seg = seg_ss;
            default:    seg = seg_ds;
        endcase
    end

    assign real_addr = {seg, 4'h0} + {4'h0, req_off[15:0]};
    assign sel_idx   = seg[15:3];
    assign sel_local = seg[2];

    for (genvar t = 0; t < 2; t++) begin : g_tbl
        sag_desc_table #(.DEPTH(TBL_DEPTH)) i_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (dt_wr_en && (dt_wr_local == 1'(t))),
            .wr_idx  (dt_wr_idx),
            .wr_data (dt_wr_data),
            .rd_idx  (sel_idx[IDX_W-1:0]),
            .rd_data (tbl_rd[t])
        );
    end

    sag_limit_chk i_lim (
        .raw   (sel_local ? tbl_rd[1] : tbl_rd[0]),
        .off   (req_off),
        .lin   (prot_addr),
        .over  (over),
        .dsize (desc_dsize)
    );

    assign prot_fault = (sel_idx >= IDX_LIMIT)
                     || (!sel_local && (sel_idx == 13'd0))
                     || over;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_addr  <= '0;
            res_dsize <= 1'b0;
        end else if (accept && !mode_prot) begin
            res_valid <= 1'b1;
            res_fault <= 1'b0;
            res_addr  <= {12'h000, real_addr};
            res_dsize <= 1'b0;
        end else if (accept && !prot_fault) begin
            res_valid <= 1'b1;
            res_fault <= 1'b0;
            res_addr  <= prot_addr;
            res_dsize <= desc_dsize;
        end else begin
            res_valid <= 1'b0;
            res_fault <= accept;
            res_addr  <= '0;
            res_dsize <= 1'b0;
        end
    end

endmodule

// File: rtl/sag_unit_chk.sv
module sag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        prot_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic        res_valid,
    input logic        res_fault,
    input logic [31:0] res_addr,
    input logic        res_dsize,
    input logic        mode_prot
);

    logic acc_real_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      acc_real_q <= 1'b0;
        else if (req_valid && req_ready) acc_real_q <= !mode_prot;
        else                             acc_real_q <= 1'b0;
    end

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_fault));

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (res_valid || res_fault));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> (!res_valid && !res_fault && res_addr == 32'd0));

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_prot |=> mode_prot);

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready && mode_prot));

    p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_prot && req_ready && prot_en) |=> !req_ready);

    p_real_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && acc_real_q) |-> (res_addr[31:20] == 12'd0 && !res_dsize));

    p_real_no_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> !acc_real_q);

endmodule

bind sag_unit sag_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot_en   (prot_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_addr  (res_addr),
    .res_dsize (res_dsize),
    .mode_prot (mode_prot)
);

// File: tb/test_sag_unit.sv
`timescale 1ns/1ps
module test_sag_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prot_en;
    logic [15:0] seg_cs, seg_ss, seg_ds;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_kind;
    logic [31:0] req_off;
    logic        dt_wr_en;
    logic        dt_wr_local;
    logic [3:0]  dt_wr_idx;
    logic [63:0] dt_wr_data;
    logic        res_valid, res_fault, res_dsize;
    logic [31:0] res_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state: 0 real, 1 switching, 2 protected
    int          m_state;
    logic [63:0] m_tbl [2][16];

    always #2.5 clk = ~clk;

    sag_unit i_sag_unit (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
        .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_off(req_off),
        .dt_wr_en(dt_wr_en), .dt_wr_local(dt_wr_local),
        .dt_wr_idx(dt_wr_idx), .dt_wr_data(dt_wr_data),
        .res_valid(res_valid), .res_fault(res_fault),
        .res_addr(res_addr), .res_dsize(res_dsize)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                            input bit g, input bit d);
        logic [63:0] r = '0;
        r[15:0]  = lim[15:0];
        r[51:48] = lim[19:16];
        r[39:16] = base[23:0];
        r[63:56] = base[31:24];
        r[55]    = g;
        r[54]    = d;
        r[52]    = 1'b1;
        r[47:40] = 8'h92;
        return r;
    endfunction

    task automatic model_calc(input bit [1:0] k, input bit [31:0] o,
                              output bit v, output bit f,
                              output bit [31:0] a, output bit d);
        longint unsigned s, idx, base, lim, effl;
        bit tl;
        logic [63:0] raw;
        v = 0; f = 0; a = 0; d = 0;
        if (k == 1)      s = seg_cs;
        else if (k == 2) s = seg_ss;
        else             s = seg_ds;
        if (m_state == 0) begin
            v = 1;
            a = 32'((s * 16 + (o & 32'hFFFF)) % (64'd1 << 20));
        end else begin
            idx = s >> 3;
            tl  = s[2];
            if (idx >= 16 || (!tl && idx == 0)) begin
                f = 1;
            end else begin
                raw  = m_tbl[tl][idx];
                base = {raw[63:56], raw[39:16]};
                lim  = {raw[51:48], raw[15:0]};
                effl = raw[55] ? lim * 4096 + 4095 : lim;
                if (o > effl) f = 1;
                else begin
                    v = 1;
                    a = 32'((base + o) % (64'd1 << 32));
                    d = raw[54];
                end
            end
        end
    endtask

    // one clock: drive after a falling edge, compare at the next falling edge
    task automatic cyc(input string tag, input bit v, input bit [1:0] k, input bit [31:0] o,
                       input bit pe = 0, input bit we = 0, input bit wl = 0,
                       input int wi = 0, input bit [63:0] wd = 0);
        bit        ev, ef, ed, rdy;
        bit [31:0] ea;
        req_valid = v; req_kind = k; req_off = o; prot_en = pe;
        dt_wr_en = we; dt_wr_local = wl; dt_wr_idx = wi[3:0]; dt_wr_data = wd;
        #1;
        rdy = (m_state != 1);
        check(tag, "req_ready", {31'd0, req_ready}, {31'd0, rdy});
        ev = 0; ef = 0; ea = 0; ed = 0;
        if (v && rdy) model_calc(k, o, ev, ef, ea, ed);
        if (we) m_tbl[wl][wi] = wd;
        if (m_state == 0 && pe) m_state = 1;
        else if (m_state == 1)  m_state = 2;
        @(negedge clk);
        check(tag, "res_valid", {31'd0, res_valid}, {31'd0, ev});
        check(tag, "res_fault", {31'd0, res_fault}, {31'd0, ef});
        check(tag, "res_addr",  res_addr, ea);
        check(tag, "res_dsize", {31'd0, res_dsize}, {31'd0, ed});
    endtask

    task automatic load(input bit wl, input int wi, input logic [63:0] wd);
        cyc("R12", 0, 0, 0, 0, 1, wl, wi, wd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; prot_en = 0; req_valid = 0; req_kind = 0; req_off = 0;
        dt_wr_en = 0; dt_wr_local = 0; dt_wr_idx = 0; dt_wr_data = 0;
        seg_cs = 16'h1400; seg_ss = 16'h2000; seg_ds = 16'hFFFF;
        m_state = 0;
        for (int t = 0; t < 2; t++) for (int i = 0; i < 16; i++) m_tbl[t][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1", "req_ready", {31'd0, req_ready}, 32'd1);
        check("R1", "res_valid", {31'd0, res_valid}, 32'd0);
        check("R1", "res_fault", {31'd0, res_fault}, 32'd0);
        check("R1", "res_addr",  res_addr, 32'd0);
        @(negedge clk);

        // real mode: R2, R3
        cyc("R2", 1, 1, 32'h0000_1200);      // 15200
        cyc("R3", 1, 2, 32'h0000_3000);      // 23000
        cyc("R2", 1, 0, 32'hABCD_FFFF);      // wraps to 0FFEF
        cyc("R3", 1, 3, 32'h0000_0010);      // data alt kind, wraps to 00000
        cyc("R10", 0, 0, 32'h0);

        // table loads
        load(0, 1,  mk_desc(32'h1000_0000, 20'h001FF, 0, 1));
        load(0, 2,  mk_desc(32'h1000_0000, 20'h001FF, 1, 0));
        load(0, 0,  mk_desc(32'h5555_0000, 20'hFFFFF, 1, 1));
        load(1, 0,  mk_desc(32'h0040_0000, 20'hFFFFF, 1, 1));
        load(1, 3,  mk_desc(32'hFFFF_F000, 20'hFFFFF, 1, 0));
        load(0, 15, mk_desc(32'h00A0_0000, 20'h00010, 0, 1));

        // R4: switch pulse with a request in the same cycle, then the gap
        cyc("R4", 1, 1, 32'h0, 1);
        cyc("R4", 1, 1, 32'h0);
        seg_cs = 16'h0008; seg_ss = 16'h0004;

        seg_ds = 16'h0008;
        cyc("R7", 1, 0, 32'h0000_01FF);      // at limit, byte scale
        cyc("R7", 1, 0, 32'h0000_0200);      // above limit
        seg_ds = 16'h0010;
        cyc("R11", 1, 0, 32'h001F_FFFF);     // at limit, 4 KiB scale, size 0
        cyc("R7", 1, 0, 32'h0020_0000);
        seg_ds = 16'h000B;
        cyc("R5", 1, 0, 32'h0000_0010);      // low selector bits ignored
        seg_ds = 16'h0000;
        cyc("R8", 1, 0, 32'h0000_0010);
        seg_ds = 16'h0003;
        cyc("R8", 1, 0, 32'h0000_0010);
        seg_ds = 16'h0004;
        cyc("R8", 1, 0, 32'h0000_0123);      // per-task index 0 valid
        seg_ds = 16'h0080;
        cyc("R9", 1, 0, 32'h0000_0000);      // index 16 out of table
        seg_ds = 16'h0078;
        cyc("R9", 1, 0, 32'h0000_0010);      // top index valid
        cyc("R7", 1, 0, 32'h0000_0011);
        seg_ds = 16'h001C;
        cyc("R6", 1, 0, 32'h0000_2000);      // base + offset wraps

        // R3 in protected mode, back to back
        cyc("R3", 1, 1, 32'h0000_0005);
        cyc("R3", 1, 2, 32'h0000_0006);
        cyc("R3", 1, 3, 32'h0000_0007);

        // R12: write and lookup of the same entry together
        seg_ds = 16'h0008;
        cyc("R12", 1, 0, 32'h0000_0010, 0, 1, 0, 1, mk_desc(32'h2000_0000, 20'h001FF, 0, 0));
        cyc("R12", 1, 0, 32'h0000_0010);

        // R4: later pulses have no effect
        cyc("R4", 1, 0, 32'h0000_0010, 1);
        cyc("R4", 1, 0, 32'h0000_0020);
        cyc("R10", 0, 0, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule